// File: doc/BRIEF.md
# Cache-to-Memory Request Sequencer

This block sits between a cache and a slow byte-wide main memory. The cache raises one of three level requests: instruction read, data read or data write. The block picks one of them, drives the memory select, direction, address and write byte, and holds them while the memory settles. It then reports completion to the cache with a one-cycle done pulse. For reads it also returns the byte it captured, along with a valid flag.

The memory's settling time is given in nanoseconds along with the clock period. The block turns these into a whole number of wait cycles, rounding up. With the defaults (80 ns and an 8 ns clock) the wait is 10 cycles. Instruction fetches and data accesses share the one controller. They use separate address outputs, and a flag tells the memory which of the two addresses applies. The cache holds its request until it sees done and then drops it.

Top module: `mem_req_ctrl`

## Requirements
- R1: A synchronous active-low reset returns the controller to idle from any state. After it, `mem_sel`, `xfer_done` and `rd_valid` are all 0.
- R2: When several requests are high together in idle, data write is served first, then data read, then instruction read.
- R3: A request is accepted in idle. In the cycle after acceptance `mem_sel` is 1.
  - `mem_rw` is 1 for a read and 0 for a write.
  - `mem_ifetch` is 1 only for an instruction read.
  - The address appears on `mem_iaddr` for an instruction read and on `mem_daddr` for data accesses.
  - For a write, the byte appears on `mem_wdata`.
- R4: While `mem_sel` is high and `xfer_done` is low, `mem_sel`, `mem_rw`, `mem_iaddr` and `mem_daddr` do not change.
- R5: `xfer_done` is high for exactly one cycle. It is the cycle that follows LAT_CYC cycles of `mem_sel` high, where LAT_CYC = ceil(MEM_DELAY_NS / CLK_PERIOD_NS). That is 10 with the defaults.
- R6: `mem_sel` is low in the cycle after `xfer_done`.
- R7: For a read, `rdata_out` holds the byte `mem_rdata` carried at the end of the last wait cycle. `rd_valid` rises together with `xfer_done` and stays high until the next request is accepted. A write leaves `rd_valid` at 0.
- R8: Requests raised while an access is in progress are ignored until the controller is back in idle. A request still held then is accepted after one idle cycle with `mem_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ifetch_req | input | 1 | Instruction read request (level) |
| dread_req | input | 1 | Data read request (level) |
| dwrite_req | input | 1 | Data write request (level) |
| iaddr_in | input | ADDR_W | Instruction address from the cache |
| daddr_in | input | ADDR_W | Data address from the cache |
| dwdata_in | input | DATA_W | Byte to write |
| mem_rdata | input | DATA_W | Byte returned by memory |
| mem_sel | output | 1 | Memory select |
| mem_rw | output | 1 | Direction: 1 read, 0 write |
| mem_ifetch | output | 1 | Current access uses the instruction address |
| mem_iaddr | output | ADDR_W | Instruction address to memory |
| mem_daddr | output | ADDR_W | Data address to memory |
| mem_wdata | output | DATA_W | Write byte to memory |
| xfer_done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read byte on `rdata_out` is valid |
| rdata_out | output | DATA_W | Captured read byte |

## Verification
The memory model in the bench drives a poison byte until the full settling time has passed. A controller that samples even one cycle early therefore returns the wrong byte. A controller whose wait count is off by one fails the exact done-cycle count.

Three simultaneous requests with distinct addresses expose a wrong priority order through the direction line and the address outputs. A fetch raised in the middle of a write would appear early on `mem_ifetch` if busy requests were not ignored.

Other faults are caught as follows:
- A reset that is applied in the middle of a wait and fails to clear select stays visible on the ports.
- `rd_valid` is checked again after idle cycles, to catch a valid flag that drops too soon.
- `rd_valid` is also checked after a write, to catch one that is set by a write.

// File: rtl/mreq_pkg.sv
// Shared types for the memory request controller.
package mreq_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} mreq_state_e;
    typedef enum logic [1:0] {OP_NONE, OP_IFETCH, OP_DREAD, OP_DWRITE} mreq_op_e;
endpackage

// File: rtl/mreq_arbiter.sv
// Fixed-priority selector over the three cache requests.
// Assumes requests are levels; the caller samples the result only in idle.
module mreq_arbiter
    import mreq_pkg::*;
(
    input  logic     ifetch_req,
    input  logic     dread_req,
    input  logic     dwrite_req,
    output mreq_op_e op
);
    // Write beats data read, data read beats instruction read.
    always_comb begin
        if (dwrite_req)      op = OP_DWRITE;
        else if (dread_req)  op = OP_DREAD;
        else if (ifetch_req) op = OP_IFETCH;
        else                 op = OP_NONE;
    end
endmodule

// File: rtl/mreq_wait_timer.sv
// Counts memory settling cycles while run is high.
// Assumes LAT >= 1; clear restarts the count; expired flags the last wait cycle.
module mreq_wait_timer #(
    parameter int LAT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT);

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LAT - 1));

    // Advance the count during the wait, hold it once it reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)        cnt <= '0;
        else if (run && !expired)   cnt <= cnt + 1'b1;
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LAT - 1)) else $error("timer count past limit"); // R5
endmodule

// File: rtl/mem_req_ctrl.sv
// Unified cache-to-memory request controller.
// Accepts one request in idle, holds select, direction and address for
// LAT_CYC cycles, then pulses done and returns read data with a valid flag.
// Assumes the cache holds its request until done and then drops it.
module mem_req_ctrl
    import mreq_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 8,
    parameter int MEM_DELAY_NS  = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ifetch_req,
    input  logic              dread_req,
    input  logic              dwrite_req,
    input  logic [ADDR_W-1:0] iaddr_in,
    input  logic [ADDR_W-1:0] daddr_in,
    input  logic [DATA_W-1:0] dwdata_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_sel,
    output logic              mem_rw,
    output logic              mem_ifetch,
    output logic [ADDR_W-1:0] mem_iaddr,
    output logic [ADDR_W-1:0] mem_daddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              xfer_done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rdata_out
);
    localparam int LAT_RAW = (MEM_DELAY_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int LAT_CYC = (LAT_RAW < 1) ? 1 : LAT_RAW;
    localparam int SCW     = $clog2(LAT_CYC + 2);

    mreq_state_e state;
    mreq_op_e    pick;
    logic        wait_over;

    mreq_arbiter u_arb (
        .ifetch_req (ifetch_req),
        .dread_req  (dread_req),
        .dwrite_req (dwrite_req),
        .op         (pick)
    );

    mreq_wait_timer #(.LAT(LAT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_IDLE),
        .run     (state == ST_WAIT),
        .expired (wait_over)
    );

    // Main sequencer: accept, wait for settling, report, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mem_sel    <= 1'b0;
            mem_rw     <= 1'b1;
            mem_ifetch <= 1'b0;
            mem_iaddr  <= '0;
            mem_daddr  <= '0;
            mem_wdata  <= '0;
            xfer_done  <= 1'b0;
            rd_valid   <= 1'b0;
            rdata_out  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pick != OP_NONE) begin
                        state      <= ST_WAIT;
                        mem_sel    <= 1'b1;
                        mem_rw     <= (pick != OP_DWRITE);
                        mem_ifetch <= (pick == OP_IFETCH);
                        rd_valid   <= 1'b0;
                        if (pick == OP_IFETCH) mem_iaddr <= iaddr_in;
                        else                   mem_daddr <= daddr_in;
                        if (pick == OP_DWRITE) mem_wdata <= dwdata_in;
                    end
                end
                ST_WAIT: begin
                    if (wait_over) begin
                        state     <= ST_DONE;
                        xfer_done <= 1'b1;
                        if (mem_rw) begin
                            rdata_out <= mem_rdata;
                            rd_valid  <= 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    state     <= ST_IDLE;
                    xfer_done <= 1'b0;
                    mem_sel   <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker-only count of select-high cycles before done.
    logic [SCW-1:0] sel_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || xfer_done || !mem_sel) sel_cnt <= '0;
        else                                 sel_cnt <= sel_cnt + 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done) else $error("done longer than one cycle"); // R5
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (sel_cnt == SCW'(LAT_CYC))) else $error("wrong latency"); // R5
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel && !xfer_done) |=> (mem_sel && $stable(mem_rw) &&
        $stable(mem_iaddr) && $stable(mem_daddr))) else $error("access moved"); // R4
    AST_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !mem_sel) else $error("select held after done"); // R6
    AST_VALID_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (xfer_done && mem_rw)) else $error("bad valid"); // R7
endmodule

// File: tb/mem_req_ctrl_test.sv
module mem_req_ctrl_test;
    localparam int LAT = 10;
    localparam logic [7:0] POISON = 8'hEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ifetch_req = 0, dread_req = 0, dwrite_req = 0;
    logic [15:0] iaddr_in = '0, daddr_in = '0;
    logic [7:0]  dwdata_in = '0, mem_rdata;
    logic        mem_sel, mem_rw, mem_ifetch, xfer_done, rd_valid;
    logic [15:0] mem_iaddr, mem_daddr;
    logic [7:0]  mem_wdata, rdata_out;

    int n_chk = 0, n_fail = 0;
    logic [7:0] store [0:255];
    int sel_age = 0;

    always #4 clk = ~clk;  // 125 MHz

    mem_req_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ifetch_req(ifetch_req), .dread_req(dread_req),
        .dwrite_req(dwrite_req), .iaddr_in(iaddr_in), .daddr_in(daddr_in),
        .dwdata_in(dwdata_in), .mem_rdata(mem_rdata), .mem_sel(mem_sel),
        .mem_rw(mem_rw), .mem_ifetch(mem_ifetch), .mem_iaddr(mem_iaddr),
        .mem_daddr(mem_daddr), .mem_wdata(mem_wdata), .xfer_done(xfer_done),
        .rd_valid(rd_valid), .rdata_out(rdata_out)
    );

    // Slow byte memory: data only settles after LAT cycles of select.
    wire [7:0] cur_a = mem_ifetch ? mem_iaddr[7:0] : mem_daddr[7:0];
    assign mem_rdata = (mem_sel && mem_rw && sel_age >= LAT - 1) ? store[cur_a] : POISON;
    always @(posedge clk) begin
        if (mem_sel && !mem_rw && sel_age == LAT - 1) store[cur_a] <= mem_wdata;
        sel_age <= mem_sel ? sel_age + 1 : 0;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_reqs(input logic i, input logic r, input logic w);
        ifetch_req = i; dread_req = r; dwrite_req = w;
    endtask

    // Called at the negedge where select was first seen; counts to done.
    task automatic wait_done(output int n);
        n = 1;
        while (!xfer_done && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    // One access of kind k (0 fetch, 1 read, 2 write) checked end to end.
    task automatic t_access(input int k, input logic [15:0] a, input logic [7:0] wd);
        int n;
        logic [7:0] exp_b;
        @(negedge clk);
        iaddr_in = a; daddr_in = a; dwdata_in = wd;
        set_reqs(k == 0, k == 1, k == 2);
        exp_b = store[a[7:0]];
        @(negedge clk);
        chk(mem_sel == 1'b1, "R3 sel", mem_sel, 1);
        chk(mem_rw == (k != 2), "R3 rw", mem_rw, k != 2);
        chk(mem_ifetch == (k == 0), "R3 ifetch", mem_ifetch, k == 0);
        chk((k == 0 ? mem_iaddr : mem_daddr) == a, "R3 addr",
            k == 0 ? mem_iaddr : mem_daddr, a);
        if (k == 2) chk(mem_wdata == wd, "R3 wdata", mem_wdata, wd);
        wait_done(n);
        set_reqs(0, 0, 0);
        chk(n == LAT + 1, "R5 latency", n, LAT + 1);
        if (k == 2) chk(rd_valid == 1'b0, "R7 write valid", rd_valid, 0);
        else begin
            chk(rd_valid == 1'b1, "R7 valid", rd_valid, 1);
            chk(rdata_out == exp_b, "R7 rdata", rdata_out, exp_b);
        end
        @(negedge clk);
        chk(mem_sel == 1'b0, "R6 sel drop", mem_sel, 0);
        chk(xfer_done == 1'b0, "R5 done pulse", xfer_done, 0);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(!mem_sel && !xfer_done && !rd_valid, "R1 reset state",
            {mem_sel, xfer_done, rd_valid}, 0);
    endtask

    task automatic t_priority();
        int n;
        @(negedge clk);
        iaddr_in = 16'h0011; daddr_in = 16'h0022; dwdata_in = 8'h5A;
        set_reqs(1, 1, 1);
        @(negedge clk);
        chk(mem_rw == 1'b0 && !mem_ifetch, "R2 write first", {mem_rw, mem_ifetch}, 0);
        wait_done(n);
        dwrite_req = 0; daddr_in = 16'h0033;
        @(negedge clk);
        @(negedge clk);
        chk(mem_rw && !mem_ifetch && mem_daddr == 16'h0033, "R2 read second",
            mem_daddr, 16'h0033);
        wait_done(n);
        chk(rdata_out == store[8'h33], "R7 read data", rdata_out, store[8'h33]);
        dread_req = 0;
        @(negedge clk);
        @(negedge clk);
        chk(mem_ifetch && mem_iaddr == 16'h0011, "R2 fetch last", mem_iaddr, 16'h0011);
        wait_done(n);
        ifetch_req = 0;
        @(negedge clk);
        chk(store[8'h22] == 8'h5A, "R2 write landed", store[8'h22], 8'h5A);
    endtask

    task automatic t_busy_ignore();
        int n;
        @(negedge clk);
        daddr_in = 16'h0040; dwdata_in = 8'hC3; iaddr_in = 16'h0077;
        set_reqs(0, 0, 1);
        @(negedge clk);
        repeat (3) @(negedge clk);
        ifetch_req = 1;
        n = 0;
        while (!xfer_done && n < 40) begin
            if (mem_ifetch || !(mem_rw == 1'b0)) n = 100;
            @(negedge clk);
            n++;
        end
        chk(n < 100, "R8 busy ignore", n, 0);
        dwrite_req = 0;
        @(negedge clk);
        chk(mem_sel == 1'b0, "R8 idle gap", mem_sel, 0);
        @(negedge clk);
        chk(mem_sel && mem_ifetch && mem_iaddr == 16'h0077, "R8 served later",
            mem_iaddr, 16'h0077);
        wait_done(n);
        ifetch_req = 0;
        @(negedge clk);
    endtask

    task automatic t_valid_hold();
        logic [7:0] b;
        t_access(1, 16'h0005, 8'h00);
        b = store[8'h05];
        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b1 && rdata_out == b, "R7 valid held", rdata_out, b);
        daddr_in = 16'h0006; dwdata_in = 8'h99;
        set_reqs(0, 0, 1);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7 valid cleared on accept", rd_valid, 0);
        while (!xfer_done) @(negedge clk);
        set_reqs(0, 0, 0);
        @(negedge clk);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        daddr_in = 16'h0009;
        set_reqs(0, 1, 0);
        repeat (4) @(negedge clk);
        chk(mem_sel == 1'b1, "R4 sel held", mem_sel, 1);
        rst_n = 0; set_reqs(0, 0, 0);
        @(negedge clk);
        chk(!mem_sel && !xfer_done && !rd_valid, "R1 reset mid-wait",
            {mem_sel, xfer_done, rd_valid}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(mem_sel == 1'b0, "R1 stays idle", mem_sel, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) store[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1;
        t_access(0, 16'h0010, 8'h00);
        t_access(1, 16'h0020, 8'h00);
        t_access(2, 16'h0030, 8'hA7);
        t_access(1, 16'h0030, 8'h00);
        t_priority();
        t_busy_ignore();
        t_valid_hold();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule